// File: doc/BRIEF.md
# Self-Programming Command Window Controller

This block is the control and status register that gates flash self-programming in a small microcontroller. Software writes a command code to the register. That write opens a short window, counted in clock cycles. A store-program strobe (SPM) or load-program strobe (LPM) that the core issues inside the window is turned into the requested action. These actions are: a page erase or page write request to the flash, re-enabling reads of the read-while-write (RWW) region, programming the boot lock bits from the R0 data, or returning the lock byte in place of program memory. If no qualifying strobe arrives, the command bits clear themselves and the block goes back to passing LPM strobes through as ordinary program-memory reads.

The block also keeps the RWW-busy flag. An erase or write request sets the flag. A later RWW-enable command clears it, but only once the flash has signalled completion. While the flag is set, ordinary reads that fall inside the RWW region are marked blocked. While the EEPROM is being written, register writes and lock-byte reads are locked out.

Top module: `spm_window_ctrl`

## Requirements
- R1: Only an accepted register write arms the window. The command is decided by write-data bits 5..0; bits 7..6 are ignored. The codes are: 6'b001001 lock mode, 6'b000011 page erase, 6'b000101 page write, 6'b010001 RWW enable. Any other value disarms. Register read data is {rww_busy, 1'b0, the armed code, or 6'b000000 when idle}.
- R2: In any armed mode, an SPM strobe is accepted on the first to fourth rising edge after the write edge. In lock mode, an accepted SPM performs stored_boot_lock &= R0[5:2], so bits can only go from 1 to 0.
- R3: In lock mode, an LPM strobe on the first to third edge after the write, with Z equal to 0x0001, produces a lock read. One cycle later rd_valid=1 and rd_lock=1, and rd_data = {2'b11, boot_lock[3:0], general_lock[1:0]}. The reset values are 4'hF and 2'b11.
- R4: The armed command clears on an accepted SPM, on a lock read, or on the fourth edge after the write when neither happened. Register read data then shows code 6'b000000.
- R5: An LPM that is not a lock read gives rd_valid=1, rd_lock=0 and rd_data=0 one cycle later. This is an ordinary program-memory read.
- R6: An SPM accepted in erase or write mode pulses flash_req for one cycle, one cycle later. flash_write is 1 for a write and 0 for an erase, and flash_addr equals Z. The same edge sets rww_busy (register bit 7).
- R7: An ordinary read with Z below RWW_LIMIT gives rd_blocked=1 while rww_busy is set, and rd_blocked=0 otherwise.
- R8: An SPM accepted in RWW-enable mode clears rww_busy only when no flash operation is outstanding. An operation is outstanding from its request until flash_done. Otherwise rww_busy is left unchanged.
- R9: While eep_busy is 1, register writes are ignored and an LPM cannot produce a lock read.
- R10: Lock-bit programming raises neither flash_req nor rww_busy.
- R11: A register write that arrives while a window is open restarts the count from zero with the new command.
- R12: After reset: register read data 0, no request, no read outputs, lock byte 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | CPU write strobe for the control register |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Control/status register read value |
| spm_strobe | input | 1 | Store-program strobe from the core |
| lpm_strobe | input | 1 | Load-program strobe from the core |
| z_ptr | input | ZW | Z-pointer address |
| r0_data | input | 8 | R0 data for lock programming |
| eep_busy | input | 1 | EEPROM write in progress |
| flash_req | output | 1 | One-cycle erase/write request to flash |
| flash_write | output | 1 | 1 = page write, 0 = page erase |
| flash_addr | output | ZW | Address of the request |
| flash_done | input | 1 | Flash operation finished (pulse) |
| rd_valid | output | 1 | Result of an LPM strobe is present |
| rd_lock | output | 1 | The result is the lock byte |
| rd_blocked | output | 1 | Ordinary read hit the busy RWW region |
| rd_data | output | 8 | Lock byte, or 0 for ordinary reads |

## Verification
A register write can land on the same edge as a strobe. The strobe is judged against the window already open, and the new command then re-arms from zero. The bench issues an SPM and a new write together, and an LPM together with a new lock write, and confirms both effects. A second overlap is the closing edge of a window meeting a late strobe: an SPM on the fourth edge must still act, while an LPM on that edge must fall through as an ordinary read. In addition, a behavioural model compares every output each cycle.

// File: rtl/spmw_pkg.sv
package spmw_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE,
        MODE_LOCK,
        MODE_ERASE,
        MODE_WRITE,
        MODE_RWWEN
    } spm_mode_e;

    localparam logic [5:0] CODE_LOCK  = 6'b001001;
    localparam logic [5:0] CODE_ERASE = 6'b000011;
    localparam logic [5:0] CODE_WRITE = 6'b000101;
    localparam logic [5:0] CODE_RWWEN = 6'b010001;

    function automatic spm_mode_e decode_cmd(input logic [5:0] code);
        case (code)
            CODE_LOCK:  return MODE_LOCK;
            CODE_ERASE: return MODE_ERASE;
            CODE_WRITE: return MODE_WRITE;
            CODE_RWWEN: return MODE_RWWEN;
            default:    return MODE_IDLE;
        endcase
    endfunction

    function automatic logic [5:0] code_of(input spm_mode_e m);
        case (m)
            MODE_LOCK:  return CODE_LOCK;
            MODE_ERASE: return CODE_ERASE;
            MODE_WRITE: return CODE_WRITE;
            MODE_RWWEN: return CODE_RWWEN;
            default:    return 6'b000000;
        endcase
    endfunction

endpackage

// File: rtl/spmw_window.sv
module spmw_window
    import spmw_pkg::*;
#(
    parameter int SPM_WIN = 4,
    parameter int LPM_WIN = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [5:0] wr_code,
    input  logic       spm_strobe,
    input  logic       lock_taken,
    output spm_mode_e  mode,
    output logic       spm_ok,
    output logic       lpm_ok
);
    localparam int CW = $clog2(SPM_WIN + 1);
    localparam logic [CW-1:0] SPM_LAST = CW'(SPM_WIN - 1);
    localparam logic [CW-1:0] SPM_LIM  = CW'(SPM_WIN);
    localparam logic [CW-1:0] LPM_LIM  = CW'(LPM_WIN);

    typedef struct packed {
        spm_mode_e       mode;
        logic [CW-1:0]   cnt;
    } win_t;

    win_t win_d, win_q;

    assign mode   = win_q.mode;
    assign spm_ok = (win_q.mode != MODE_IDLE) && (win_q.cnt < SPM_LIM);
    assign lpm_ok = (win_q.mode == MODE_LOCK) && (win_q.cnt < LPM_LIM);

    always_comb begin
        win_d = win_q;
        if (wr_en) begin
            win_d.mode = decode_cmd(wr_code);
            win_d.cnt  = '0;
        end else if (win_q.mode != MODE_IDLE) begin
            if ((spm_strobe && spm_ok) || lock_taken || (win_q.cnt == SPM_LAST)) begin
                win_d.mode = MODE_IDLE;
                win_d.cnt  = '0;
            end else begin
                win_d.cnt = win_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '{mode: MODE_IDLE, cnt: '0};
        end else begin
            win_q <= win_d;
        end
    end

    // R4
    lpm_within_spm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_ok |-> spm_ok);

    // R4
    window_lapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q.mode != MODE_IDLE && !wr_en && win_q.cnt == SPM_LAST) |=> (win_q.mode == MODE_IDLE));

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && decode_cmd(wr_code) != MODE_IDLE) |=> (spm_ok && win_q.mode != MODE_IDLE));

endmodule

// File: rtl/spmw_lock.sv
module spmw_lock #(
    parameter logic [3:0] BOOT_INIT = 4'hF,
    parameter logic [1:0] GEN_INIT  = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic [3:0] prog_mask,
    output logic [7:0] lock_byte
);
    typedef struct packed {
        logic [3:0] boot;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (prog_en) begin
            lk_d.boot = lk_q.boot & prog_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q <= '{boot: BOOT_INIT};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign lock_byte = {2'b11, lk_q.boot, GEN_INIT};

    // R2
    lock_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lk_q.boot & ~$past(lk_q.boot)) == 4'b0000));

    // R2
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(lk_q.boot));

endmodule

// File: rtl/spmw_rww.sv
module spmw_rww #(
    parameter int ZW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire_prog,
    input  logic          prog_write,
    input  logic          fire_rwwen,
    input  logic [ZW-1:0] z_ptr,
    input  logic          flash_done,
    output logic          flash_req,
    output logic          flash_write,
    output logic [ZW-1:0] flash_addr,
    output logic          rww_busy
);
    typedef struct packed {
        logic          req;
        logic          wr;
        logic [ZW-1:0] addr;
        logic          busy;
        logic          active;
    } rww_t;

    rww_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (flash_done) begin
            st_d.active = 1'b0;
        end
        if (fire_prog) begin
            st_d.req    = 1'b1;
            st_d.wr     = prog_write;
            st_d.addr   = z_ptr;
            st_d.busy   = 1'b1;
            st_d.active = 1'b1;
        end
        if (fire_rwwen && !st_q.active) begin
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flash_req   = st_q.req;
    assign flash_write = st_q.wr;
    assign flash_addr  = st_q.addr;
    assign rww_busy    = st_q.busy;

    // R6
    req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |-> st_q.busy);

    // R8
    busy_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> !$past(st_q.active));

    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.req |=> (!st_q.req || $past(fire_prog)));

endmodule

// File: rtl/spm_window_ctrl.sv
module spm_window_ctrl
    import spmw_pkg::*;
#(
    parameter int          ZW        = 16,
    parameter int          SPM_WIN   = 4,
    parameter int          LPM_WIN   = 3,
    parameter logic [15:0] RWW_LIMIT = 16'h3800,
    parameter logic [3:0]  BOOT_INIT = 4'hF,
    parameter logic [1:0]  GEN_INIT  = 2'b11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          spm_strobe,
    input  logic          lpm_strobe,
    input  logic [ZW-1:0] z_ptr,
    input  logic [7:0]    r0_data,
    input  logic          eep_busy,
    output logic          flash_req,
    output logic          flash_write,
    output logic [ZW-1:0] flash_addr,
    input  logic          flash_done,
    output logic          rd_valid,
    output logic          rd_lock,
    output logic          rd_blocked,
    output logic [7:0]    rd_data
);
    localparam logic [ZW-1:0] LOCK_Z  = ZW'(1);
    localparam logic [ZW-1:0] RWW_TOP = ZW'(RWW_LIMIT);

    typedef struct packed {
        logic       valid;
        logic       lock;
        logic       blocked;
        logic [7:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    spm_mode_e  mode;
    logic       spm_ok, lpm_ok;
    logic       wr_en, spm_fire, lock_read, plain_read;
    logic       rww_busy;
    logic [7:0] lock_byte;
    logic       unused_bits;

    assign unused_bits = ^{reg_wdata[7:6], r0_data[7:6], r0_data[1:0]};

    assign wr_en      = reg_we && !eep_busy;
    assign spm_fire   = spm_strobe && spm_ok;
    assign lock_read  = lpm_strobe && lpm_ok && !eep_busy && (z_ptr == LOCK_Z);
    assign plain_read = lpm_strobe && !lock_read;

    spmw_window #(.SPM_WIN(SPM_WIN), .LPM_WIN(LPM_WIN)) i_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_code    (reg_wdata[5:0]),
        .spm_strobe (spm_strobe),
        .lock_taken (lock_read),
        .mode       (mode),
        .spm_ok     (spm_ok),
        .lpm_ok     (lpm_ok)
    );

    spmw_lock #(.BOOT_INIT(BOOT_INIT), .GEN_INIT(GEN_INIT)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (spm_fire && mode == MODE_LOCK),
        .prog_mask (r0_data[5:2]),
        .lock_byte (lock_byte)
    );

    spmw_rww #(.ZW(ZW)) i_rww (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire_prog   (spm_fire && (mode == MODE_ERASE || mode == MODE_WRITE)),
        .prog_write  (mode == MODE_WRITE),
        .fire_rwwen  (spm_fire && mode == MODE_RWWEN),
        .z_ptr       (z_ptr),
        .flash_done  (flash_done),
        .flash_req   (flash_req),
        .flash_write (flash_write),
        .flash_addr  (flash_addr),
        .rww_busy    (rww_busy)
    );

    always_comb begin
        rd_d         = '0;
        rd_d.valid   = lpm_strobe;
        rd_d.lock    = lock_read;
        rd_d.data    = lock_read ? lock_byte : 8'h00;
        rd_d.blocked = plain_read && rww_busy && (z_ptr < RWW_TOP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata  = {rww_busy, 1'b0, code_of(mode)};
    assign rd_valid   = rd_q.valid;
    assign rd_lock    = rd_q.lock;
    assign rd_blocked = rd_q.blocked;
    assign rd_data    = rd_q.data;

    // R9
    no_lock_during_eep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.lock |-> !$past(eep_busy));

    // R7
    blocked_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q.blocked |-> $past(rww_busy));

    // R10
    lock_prog_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spm_fire && mode == MODE_LOCK) |=> !flash_req);

    // R5
    read_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q.lock || rd_q.blocked) |-> (rd_q.valid && !(rd_q.lock && rd_q.blocked)));

endmodule

// File: tb/test_spm_window_ctrl.sv
module test_spm_window_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ZW = 16;
    localparam int RWW_LIM = 16'h3800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic spm_strobe = 1'b0, lpm_strobe = 1'b0;
    logic [ZW-1:0] z_ptr = '0;
    logic [7:0] r0_data = 8'hFF;
    logic eep_busy = 1'b0, flash_done = 1'b0;
    logic [7:0] reg_rdata, rd_data;
    logic flash_req, flash_write, rd_valid, rd_lock, rd_blocked;
    logic [ZW-1:0] flash_addr;

    int tests = 0, fails = 0;
    string cur_req = "R12";
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spm_window_ctrl i_spm_window_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe),
        .z_ptr(z_ptr), .r0_data(r0_data), .eep_busy(eep_busy),
        .flash_req(flash_req), .flash_write(flash_write), .flash_addr(flash_addr),
        .flash_done(flash_done), .rd_valid(rd_valid), .rd_lock(rd_lock),
        .rd_blocked(rd_blocked), .rd_data(rd_data)
    );

    // behavioural reference: mode 0 idle, 1 lock, 2 erase, 3 write, 4 rww enable
    int m_mode, m_cnt;
    logic [3:0] m_boot;
    logic m_busy, m_active, m_req, m_wr, m_valid, m_lock, m_blk;
    logic [ZW-1:0] m_addr;
    logic [7:0] m_data;

    function automatic int code_mode(input logic [5:0] c);
        if (c == 6'b001001) return 1;
        if (c == 6'b000011) return 2;
        if (c == 6'b000101) return 3;
        if (c == 6'b010001) return 4;
        return 0;
    endfunction

    function automatic logic [5:0] mode_code(input int m);
        case (m)
            1: return 6'b001001;
            2: return 6'b000011;
            3: return 6'b000101;
            4: return 6'b010001;
            default: return 6'b000000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_boot = 4'hF; m_busy = 0; m_active = 0;
            m_req = 0; m_wr = 0; m_addr = '0; m_valid = 0; m_lock = 0; m_blk = 0; m_data = 0;
        end else begin
            bit sok, lok, sf, lr, act_old;
            sok = (m_mode != 0) && (m_cnt < 4);
            lok = (m_mode == 1) && (m_cnt < 3);
            sf = spm_strobe && sok;
            lr = lpm_strobe && lok && !eep_busy && (z_ptr == 1);
            m_valid = lpm_strobe;
            m_lock = lr;
            m_data = lr ? {2'b11, m_boot, 2'b11} : 8'h00;
            m_blk = lpm_strobe && !lr && m_busy && (z_ptr < RWW_LIM);
            act_old = m_active;
            m_req = 0;
            if (flash_done) m_active = 0;
            if (sf && m_mode == 1) m_boot = m_boot & r0_data[5:2];
            if (sf && (m_mode == 2 || m_mode == 3)) begin
                m_req = 1; m_wr = (m_mode == 3); m_addr = z_ptr; m_busy = 1; m_active = 1;
            end
            if (sf && m_mode == 4 && !act_old) m_busy = 0;
            if (reg_we && !eep_busy) begin
                m_mode = code_mode(reg_wdata[5:0]); m_cnt = 0;
            end else if (m_mode != 0) begin
                if (sf || lr || m_cnt == 3) begin m_mode = 0; m_cnt = 0; end
                else m_cnt++;
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            logic [7:0] exp_r;
            exp_r = {m_busy, 1'b0, mode_code(m_mode)};
            tests++;
            if (reg_rdata !== exp_r || flash_req !== m_req || flash_write !== m_wr ||
                flash_addr !== m_addr || rd_valid !== m_valid || rd_lock !== m_lock ||
                rd_blocked !== m_blk || rd_data !== m_data) begin
                fails++;
                $display("FAIL %s model: rdata=%h/%h req=%b/%b wr=%b/%b addr=%h/%h valid=%b/%b lock=%b/%b blk=%b/%b data=%h/%h (actual/expected)",
                    cur_req, reg_rdata, exp_r, flash_req, m_req, flash_write, m_wr,
                    flash_addr, m_addr, rd_valid, m_valid, rd_lock, m_lock,
                    rd_blocked, m_blk, rd_data, m_data);
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1; reg_wdata = v; @(negedge clk); reg_we = 0;
    endtask
    task automatic spm(input logic [15:0] z, input logic [7:0] r0);
        spm_strobe = 1; z_ptr = z; r0_data = r0; @(negedge clk); spm_strobe = 0;
    endtask
    task automatic lpm(input logic [15:0] z);
        lpm_strobe = 1; z_ptr = z; @(negedge clk); lpm_strobe = 0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic done_pulse();
        flash_done = 1; @(negedge clk); flash_done = 0;
    endtask

    task automatic summary();
        done_flag = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R12";
        check("R12", "reset rdata", reg_rdata, 8'h00);
        check("R12", "reset req", flash_req, 0);
        check("R12", "reset valid", rd_valid, 0);

        // R1 arming and readback; bit 7 ignored
        cur_req = "R1";
        wr(8'h89);
        check("R1", "lock code readback", reg_rdata, 8'h09);
        idle(4);
        wr(8'h07);
        check("R1", "unknown code disarms", reg_rdata, 8'h00);

        // R3 lock read on third edge, reset lock byte
        cur_req = "R3";
        wr(8'h09); idle(2); lpm(16'h0001);
        check("R3", "lock read flag", rd_lock, 1);
        check("R3", "lock byte reset value", rd_data, 8'hFF);
        check("R4", "cleared after lock read", reg_rdata, 8'h00);

        // R2 SPM on fourth edge programs lock bits
        cur_req = "R2";
        wr(8'h09); idle(3); spm(16'h1234, 8'b1101_0111);
        check("R10", "no request from lock prog", flash_req, 0);
        check("R4", "cleared after SPM", reg_rdata, 8'h00);
        wr(8'h09); lpm(16'h0001);
        check("R2", "programmed lock byte", rd_data, 8'hD7);
        // further programming cannot set bits
        wr(8'h09); spm(16'h0001, 8'hFF);
        wr(8'h09); lpm(16'h0001);
        check("R2", "bits stay cleared", rd_data, 8'hD7);

        // R4 lapse; LPM on fourth edge is ordinary
        cur_req = "R4";
        wr(8'h09); idle(3);
        check("R4", "still armed after three edges", reg_rdata, 8'h09);
        lpm(16'h0001);
        check("R5", "late LPM ordinary", rd_lock, 0);
        check("R5", "late LPM valid", rd_valid, 1);
        check("R4", "lapsed", reg_rdata, 8'h00);
        wr(8'h09); idle(4); spm(16'h0000, 8'h00);
        wr(8'h09); lpm(16'h0001);
        check("R4", "SPM after lapse ignored", rd_data, 8'hD7);

        // R6 erase and write requests
        cur_req = "R6";
        wr(8'h03); spm(16'h0240, 8'hFF);
        check("R6", "erase req", flash_req, 1);
        check("R6", "erase op", flash_write, 0);
        check("R6", "erase addr", flash_addr, 16'h0240);
        check("R6", "busy bit", reg_rdata[7], 1);

        // R7 blocked reads
        cur_req = "R7";
        lpm(16'h0100);
        check("R7", "low read blocked", rd_blocked, 1);
        lpm(16'h3900);
        check("R7", "high read not blocked", rd_blocked, 0);

        // R8 RWW enable while active has no effect
        cur_req = "R8";
        wr(8'h11); spm(16'h0000, 8'hFF);
        check("R8", "busy kept while active", reg_rdata[7], 1);
        done_pulse();
        wr(8'h11); idle(1); spm(16'h0000, 8'hFF);
        check("R8", "busy cleared", reg_rdata[7], 0);
        lpm(16'h0100);
        check("R7", "not blocked after enable", rd_blocked, 0);

        cur_req = "R6";
        wr(8'h05); idle(2); spm(16'h0080, 8'hFF);
        check("R6", "write op", flash_write, 1);
        idle(2); done_pulse();

        // R9 EEPROM busy
        cur_req = "R9";
        eep_busy = 1;
        wr(8'h09);
        check("R9", "write ignored", reg_rdata[5:0], 6'h00);
        eep_busy = 0;
        wr(8'h09); eep_busy = 1; lpm(16'h0001);
        check("R9", "lock read suppressed", rd_lock, 0);
        eep_busy = 0;
        check("R9", "window still open", reg_rdata[5:0], 6'h09);
        idle(4);

        // R11 restart, same-cycle write and strobe
        cur_req = "R11";
        wr(8'h09); idle(3); wr(8'h09); idle(3);
        check("R11", "restarted window open", reg_rdata[5:0], 6'h09);
        spm(16'h0000, 8'b1111_1011);
        reg_we = 1; reg_wdata = 8'h09; spm_strobe = 1; r0_data = 8'hFF;
        wr(8'h09);
        spm_strobe = 0;
        check("R11", "new window armed", reg_rdata[5:0], 6'h09);
        lpm(16'h0001);
        check("R2", "lock byte after bit clear", rd_data, 8'hD3);
        wr(8'h03); lpm_strobe = 1; z_ptr = 16'h0001; wr(8'h09); lpm_strobe = 0;
        check("R5", "LPM in erase mode ordinary", rd_lock, 0);
        check("R11", "lock window armed", reg_rdata[5:0], 6'h09);
        idle(5);

        summary();
    end
endmodule